// File: doc/BRIEF.md
# Shift-Capable ALU Stage

This block is the execute stage of a single-cycle RISC datapath. It takes the two register read values (the first source, rs, and the second source, rt), the current instruction word and a two-bit ALU-op code from the main decoder. From these it decodes a five-bit internal operation and picks the operands. It returns a data-width result together with a flag that is high when that result is zero. The stage is purely combinational, so the result follows the inputs within the same cycle.

Besides add, subtract, AND, OR and signed set-less-than, the stage performs logical shifts by an immediate amount. For a shift, the first ALU operand is not rs. It is the five-bit shift-amount field of the instruction, zero-extended. The value that gets shifted is always rt. The shift operations exist only as R-type function codes. The register file, the writeback selection (a shift result goes to rd) and the main decoder are outside this block.

Top module: `shift_alu_stage`

## Requirements
- R1: ALU-op 2'b00 gives rs + rt and ALU-op 2'b01 gives rs - rt, both modulo 2^32. ALU-op 2'b11 also gives rs + rt. In these cases the function field is ignored.
- R2: With ALU-op 2'b10, the function field instr[5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 bitwise AND, 0x25 bitwise OR, 0x2A signed set-less-than (result 1 or 0). Any function code not listed here gives rs + rt.
- R3: The shift-amount field instr[10:6] affects only shift operations. For every other operation, changing those bits leaves the result unchanged.
- R4: With ALU-op 2'b10 and function 0x00, the result is rt shifted left by instr[10:6]. The vacated low bits are filled with zeros, and rs has no effect on the result.
- R5: With ALU-op 2'b10 and function 0x02, the result is rt shifted right logically by instr[10:6]. The vacated high bits are filled with zeros, and rs has no effect on the result.
- R6: A shift whose amount is 0 returns rt unchanged.
- R7: o_zero is 1 exactly when o_result is all zeros, whatever operation produced the result.
- R8: Function codes 0x00 and 0x02 select a shift only under ALU-op 2'b10. Under any other ALU-op they follow R1.
- R9: The stage holds no state. o_result and o_zero follow the current inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_rs_val | input | 32 | First register read value (rs) |
| i_rt_val | input | 32 | Second register read value (rt); the value that is shifted |
| i_instr | input | 32 | Current instruction word; bits [10:6] are the shift amount and bits [5:0] the function code |
| i_alu_op | input | 2 | Operation class from the main decoder |
| o_result | output | 32 | ALU result |
| o_zero | output | 1 | High when o_result is zero |

## Verification
The embedded checks assume that every input is at a known value whenever it is evaluated. They are skipped while any input is unknown, so the stage is not judged before the bench has first driven it. The checks also take the ALU-op input to be the only indication of an R-type instruction, which means the function field carries meaning only under the R-type code. The stimulus drives every input from a task, one clock after the previous vector. It draws function codes from the defined set and from arbitrary values, and it mixes all four ALU-op codes so that shift function codes also appear outside the R-type class.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

   localparam int FUNCT_W = 6;

   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_RTYPE = 2'b10,
      CLS_ADD2  = 2'b11
   } alu_class_e;

   typedef enum logic [4:0] {
      ALU_ADD = 5'd0,
      ALU_SUB = 5'd1,
      ALU_AND = 5'd2,
      ALU_OR  = 5'd3,
      ALU_SLT = 5'd4,
      ALU_SLL = 5'd5,
      ALU_SRL = 5'd6
   } alu_ctrl_e;

   localparam logic [FUNCT_W-1:0] FN_SLL = 6'h00;
   localparam logic [FUNCT_W-1:0] FN_SRL = 6'h02;
   localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
   localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
   localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
   localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
   localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import shift_alu_pkg::*;
(
   input  logic [1:0]         i_alu_op,
   input  logic [FUNCT_W-1:0] i_funct,
   output alu_ctrl_e          o_ctrl,
   output logic               o_is_shift
);

   always_comb begin
      o_ctrl = ALU_ADD;
      unique case (alu_class_e'(i_alu_op))
         CLS_SUB:   o_ctrl = ALU_SUB;
         CLS_RTYPE: begin
            case (i_funct)
               FN_ADD:  o_ctrl = ALU_ADD;
               FN_SUB:  o_ctrl = ALU_SUB;
               FN_AND:  o_ctrl = ALU_AND;
               FN_OR:   o_ctrl = ALU_OR;
               FN_SLT:  o_ctrl = ALU_SLT;
               FN_SLL:  o_ctrl = ALU_SLL;
               FN_SRL:  o_ctrl = ALU_SRL;
               default: o_ctrl = ALU_ADD;
            endcase
         end
         default:   o_ctrl = ALU_ADD;
      endcase
   end

   assign o_is_shift = (o_ctrl == ALU_SLL) || (o_ctrl == ALU_SRL);

   always_comb begin
      if (!$isunknown({i_alu_op, i_funct}))
         AST_SHIFT_ONLY_RTYPE: assert (!o_is_shift || (i_alu_op == CLS_RTYPE)); // R8
   end

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input  logic               i_is_shift,
   input  logic [DATA_W-1:0]  i_rs_val,
   input  logic [DATA_W-1:0]  i_rt_val,
   input  logic [SHAMT_W-1:0] i_shamt,
   output logic [DATA_W-1:0]  o_op_a,
   output logic [DATA_W-1:0]  o_op_b
);

   localparam int PAD_W = DATA_W - SHAMT_W;

   assign o_op_a = i_is_shift ? {{PAD_W{1'b0}}, i_shamt} : i_rs_val;
   assign o_op_b = i_rt_val;

   always_comb begin
      if (!$isunknown({i_is_shift, i_rs_val}))
         AST_SHAMT_ONLY_SHIFT: assert (i_is_shift || (o_op_a == i_rs_val)); // R3
   end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter bit LEFT    = 1'b1,
   parameter bit STAGED  = 1'b1
) (
   input  logic [DATA_W-1:0]  i_val,
   input  logic [SHAMT_W-1:0] i_amt,
   output logic [DATA_W-1:0]  o_val
);

   generate
      if (STAGED) begin : g_staged
         logic [DATA_W-1:0] stg [0:SHAMT_W];
         assign stg[0] = i_val;
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            if (LEFT) begin : g_l
               assign stg[k+1] = i_amt[k] ? {stg[k][DATA_W-1-STEP:0], {STEP{1'b0}}} : stg[k];
            end else begin : g_r
               assign stg[k+1] = i_amt[k] ? {{STEP{1'b0}}, stg[k][DATA_W-1:STEP]} : stg[k];
            end
         end
         assign o_val = stg[SHAMT_W];
      end else begin : g_flat
         if (LEFT) begin : g_l
            assign o_val = i_val << i_amt;
         end else begin : g_r
            assign o_val = i_val >> i_amt;
         end
      end
   endgenerate

endmodule

// File: rtl/alu_core.sv
module alu_core
   import shift_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter bit STAGED  = 1'b1
) (
   input  alu_ctrl_e          i_ctrl,
   input  logic [DATA_W-1:0]  i_a,
   input  logic [DATA_W-1:0]  i_b,
   output logic [DATA_W-1:0]  o_y
);

   logic [DATA_W-1:0]  sll_y;
   logic [DATA_W-1:0]  srl_y;
   logic [SHAMT_W-1:0] amt;
   logic [DATA_W-1:0]  low_mask;
   logic [DATA_W-1:0]  high_mask;

   assign amt = i_a[SHAMT_W-1:0];

   alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1), .STAGED(STAGED)) u_sll (
      .i_val(i_b), .i_amt(amt), .o_val(sll_y));

   alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0), .STAGED(STAGED)) u_srl (
      .i_val(i_b), .i_amt(amt), .o_val(srl_y));

   always_comb begin
      unique case (i_ctrl)
         ALU_SUB: o_y = i_a - i_b;
         ALU_AND: o_y = i_a & i_b;
         ALU_OR:  o_y = i_a | i_b;
         ALU_SLT: o_y = {{(DATA_W-1){1'b0}}, ($signed(i_a) < $signed(i_b))};
         ALU_SLL: o_y = sll_y;
         ALU_SRL: o_y = srl_y;
         default: o_y = i_a + i_b;
      endcase
   end

   assign low_mask  = ~({DATA_W{1'b1}} << amt);
   assign high_mask = ~({DATA_W{1'b1}} >> amt);

   always_comb begin
      if (!$isunknown({i_ctrl, i_a, i_b})) begin
         AST_SLL_LOW_ZERO: assert ((i_ctrl != ALU_SLL) || ((o_y & low_mask) == '0)); // R4
         AST_SRL_HIGH_ZERO: assert ((i_ctrl != ALU_SRL) || ((o_y & high_mask) == '0)); // R5
         AST_SHIFT_ZERO_PASS: assert (!((i_ctrl == ALU_SLL || i_ctrl == ALU_SRL) && amt == '0) || (o_y == i_b)); // R6
         AST_SLT_IS_BOOL: assert ((i_ctrl != ALU_SLT) || (o_y[DATA_W-1:1] == '0)); // R2
      end
   end

endmodule

// File: rtl/shift_alu_stage.sv
module shift_alu_stage
   import shift_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int INSTR_W   = 32,
   parameter int SHAMT_LSB = 6,
   parameter bit STAGED    = 1'b1
) (
   input  logic [DATA_W-1:0]  i_rs_val,
   input  logic [DATA_W-1:0]  i_rt_val,
   input  logic [INSTR_W-1:0] i_instr,
   input  logic [1:0]         i_alu_op,
   output logic [DATA_W-1:0]  o_result,
   output logic               o_zero
);

   localparam int SHAMT_W  = $clog2(DATA_W);
   localparam int SHAMT_HI = SHAMT_LSB + SHAMT_W - 1;

   generate
      if ((DATA_W < 8) || ((1 << SHAMT_W) != DATA_W)) begin : g_bad_width
         $error("shift_alu_stage: DATA_W must be a power of two of at least 8");
      end
      if (SHAMT_HI >= INSTR_W) begin : g_bad_field
         $error("shift_alu_stage: shift-amount field does not fit in the instruction");
      end
      if (SHAMT_LSB < FUNCT_W) begin : g_bad_overlap
         $error("shift_alu_stage: shift-amount field overlaps the function field");
      end
   endgenerate

   alu_ctrl_e          ctrl;
   logic               is_shift;
   logic [DATA_W-1:0]  op_a;
   logic [DATA_W-1:0]  op_b;
   logic [SHAMT_W-1:0] shamt;
   logic               unused_instr;

   assign shamt        = i_instr[SHAMT_HI:SHAMT_LSB];
   assign unused_instr = ^{i_instr[INSTR_W-1:SHAMT_HI+1], i_instr[SHAMT_LSB-1:FUNCT_W]};

   alu_op_decode u_dec (
      .i_alu_op  (i_alu_op),
      .i_funct   (i_instr[FUNCT_W-1:0]),
      .o_ctrl    (ctrl),
      .o_is_shift(is_shift)
   );

   alu_operand_sel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_sel (
      .i_is_shift(is_shift),
      .i_rs_val  (i_rs_val),
      .i_rt_val  (i_rt_val),
      .i_shamt   (shamt),
      .o_op_a    (op_a),
      .o_op_b    (op_b)
   );

   alu_core #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .STAGED(STAGED)) u_core (
      .i_ctrl(ctrl),
      .i_a   (op_a),
      .i_b   (op_b),
      .o_y   (o_result)
   );

   assign o_zero = ~|o_result;

   always_comb begin
      if (!$isunknown({i_alu_op, i_instr[FUNCT_W-1:0], i_rt_val}))
         AST_SHIFT_RT_ONLY: assert (!is_shift || (op_b == i_rt_val)); // R4
   end

endmodule

// File: tb/shift_alu_stage_tb.sv
`timescale 1ns/1ps
module shift_alu_stage_tb;

   logic        clk = 1'b0;
   logic [31:0] rs, rt, instr;
   logic [1:0]  aop;
   logic [31:0] res;
   logic        zf;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   shift_alu_stage u_dut (
      .i_rs_val(rs), .i_rt_val(rt), .i_instr(instr), .i_alu_op(aop),
      .o_result(res), .o_zero(zf));

   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] ins, input logic [1:0] op);
      int sh;
      sh = int'(ins[10:6]);
      if (op == 2'b01) return a - b;
      if (op != 2'b10) return a + b;
      case (ins[5:0])
         6'h22:   return a - b;
         6'h24:   return a & b;
         6'h25:   return a | b;
         6'h2A:   return (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
         6'h00: begin
            logic [31:0] v = b;
            for (int i = 0; i < sh; i++) v = {v[30:0], 1'b0};
            return v;
         end
         6'h02: begin
            logic [31:0] v = b;
            for (int i = 0; i < sh; i++) v = {1'b0, v[31:1]};
            return v;
         end
         default: return a + b;
      endcase
   endfunction

   function automatic logic [31:0] mk(input logic [4:0] sh, input logic [5:0] fn);
      return {6'h00, 5'd9, 5'd10, 5'd11, sh, fn};
   endfunction

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] ins,
                        input logic [1:0] op, input string tag);
      logic [31:0] exp;
      @(posedge clk);
      #1;
      rs = a; rt = b; instr = ins; aop = op;
      exp = model(a, b, ins, op);
      @(negedge clk);
      checks++;
      if (res !== exp) begin
         errors++;
         $display("FAIL %s result: actual %h expected %h (op %b instr %h)", tag, res, exp, op, ins);
      end
      checks++;
      if (zf !== (exp == 32'd0)) begin
         errors++;
         $display("FAIL R7 zero flag (%s): actual %b expected %b", tag, zf, exp == 32'd0);
      end
   endtask

   task automatic same_result(input logic [31:0] a, input logic [31:0] b, input logic [31:0] i1,
                              input logic [31:0] i2, input logic [1:0] op, input string tag);
      logic [31:0] first;
      apply(a, b, i1, op, tag);
      first = res;
      apply(a, b, i2, op, tag);
      checks++;
      if (res !== first) begin
         errors++;
         $display("FAIL %s ignored field changed result: actual %h expected %h", tag, res, first);
      end
   endtask

   initial begin
      rs = '0; rt = '0; instr = '0; aop = 2'b00;
      @(negedge clk);
      checks++;
      if (res !== 32'd0 || zf !== 1'b1) begin
         errors++;
         $display("FAIL R7 initial state: actual %h/%b expected 0/1", res, zf);
      end
      // R1
      apply(32'hFFFF_FFFF, 32'd1, mk(5'd3, 6'h22), 2'b00, "R1 add wrap");
      apply(32'd5, 32'd7, mk(5'd0, 6'h00), 2'b01, "R1 sub");
      apply(32'h1234, 32'h1111, mk(5'd4, 6'h24), 2'b11, "R1 class 11 add");
      // R2
      apply(32'h8000_0000, 32'h8000_0000, mk(5'd0, 6'h20), 2'b10, "R2 add");
      apply(32'd9, 32'd9, mk(5'd0, 6'h22), 2'b10, "R2 sub zero");
      apply(32'hF0F0_F0F0, 32'hFF00_FF00, mk(5'd0, 6'h24), 2'b10, "R2 and");
      apply(32'hF0F0_0000, 32'h0000_0F0F, mk(5'd0, 6'h25), 2'b10, "R2 or");
      apply(32'hFFFF_FFFF, 32'd1, mk(5'd0, 6'h2A), 2'b10, "R2 slt negative");
      apply(32'd1, 32'hFFFF_FFFF, mk(5'd0, 6'h2A), 2'b10, "R2 slt false");
      apply(32'd3, 32'd4, mk(5'd0, 6'h3F), 2'b10, "R2 unlisted funct");
      // R3
      same_result(32'h55AA, 32'h0F0F, mk(5'd0, 6'h25), mk(5'd31, 6'h25), 2'b10, "R3 or");
      same_result(32'd100, 32'd30, mk(5'd2, 6'h22), mk(5'd17, 6'h22), 2'b10, "R3 sub");
      // R4
      apply(32'hDEAD_BEEF, 32'h0000_0001, mk(5'd31, 6'h00), 2'b10, "R4 sll 31");
      apply(32'h0, 32'hFFFF_FFFF, mk(5'd4, 6'h00), 2'b10, "R4 sll fill");
      same_result(32'h1, 32'h0000_00F3, mk(5'd8, 6'h00), mk(5'd8, 6'h00), 2'b10, "R4 rs ignored a");
      apply(32'hFFFF_FFFF, 32'h0000_00F3, mk(5'd8, 6'h00), 2'b10, "R4 rs ignored b");
      apply(32'h0, 32'h8000_0000, mk(5'd1, 6'h00), 2'b10, "R4 sll out zero");
      // R5
      apply(32'h7, 32'h8000_0000, mk(5'd31, 6'h02), 2'b10, "R5 srl 31");
      apply(32'h0, 32'hFFFF_FFFF, mk(5'd4, 6'h02), 2'b10, "R5 srl zero fill");
      apply(32'h0, 32'h0000_0001, mk(5'd1, 6'h02), 2'b10, "R5 srl out zero");
      // R6
      apply(32'h1234_5678, 32'hCAFE_F00D, mk(5'd0, 6'h00), 2'b10, "R6 sll by 0");
      apply(32'h1234_5678, 32'hCAFE_F00D, mk(5'd0, 6'h02), 2'b10, "R6 srl by 0");
      // R8
      apply(32'd10, 32'd3, mk(5'd5, 6'h00), 2'b00, "R8 sll funct under add");
      apply(32'd10, 32'd3, mk(5'd5, 6'h02), 2'b01, "R8 srl funct under sub");
      apply(32'd10, 32'd3, mk(5'd5, 6'h00), 2'b11, "R8 sll funct under class 11");
      // R9: random traffic, one vector per cycle
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] a, b, ins;
         logic [1:0]  op;
         int          pick;
         a = $urandom; b = $urandom; ins = $urandom; op = 2'($urandom);
         pick = $urandom_range(0, 8);
         case (pick)
            0: ins[5:0] = 6'h00;
            1: ins[5:0] = 6'h02;
            2: ins[5:0] = 6'h20;
            3: ins[5:0] = 6'h22;
            4: ins[5:0] = 6'h24;
            5: ins[5:0] = 6'h25;
            6: ins[5:0] = 6'h2A;
            default: ;
         endcase
         if (n % 7 == 0) b = a;
         apply(a, b, ins, op, "R9 random");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog expired: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule